// File: doc/BRIEF.md
# Input Change-of-State Detector

This block watches a small general-purpose input port for level changes. The lowest four inputs are brought into the clock domain through a two-flop synchronizer. On every pulse of a slow sampling tick, which is generated elsewhere, each input is sampled. A new level is accepted only when two consecutive ticks both see it. In practice this means an input change must persist for one to two tick periods before it is recognised, and a shorter glitch is filtered out.

Each accepted transition, whether rising or falling, latches a sticky change flag. A read of the change register clears the flags. That register returns the four flags in its low nibble and the four filtered levels in its high nibble. A read of the raw port returns all seven unlatched input pins, with the top bit fixed at one. An interrupt output is raised when it is enabled and any flag is set. The CPU reads through a single read-data bus whose content is chosen by the two read strobes.

Top module: `icd_top`

## Requirements
- R1: While `rd_port` is high and `rd_chg` is low, `rd_data` equals {1'b1, `pin_in[6:0]`} in the same cycle. When neither strobe is high, `rd_data` is zero.
- R2: While `rd_chg` is high, `rd_data[3:0]` holds the change flags for inputs 3..0 and `rd_data[7:4]` holds their filtered levels. Bit n of each nibble belongs to input n. `rd_chg` takes priority over `rd_port`.
- R3: A filtered level takes a new value only on a tick where the synchronized input matches the sample taken on the previous tick and differs from the current filtered level. An input that differs from the filtered level on a single tick only leaves both the level and the flag unchanged.
- R4: An accepted rising transition sets the input's change flag, and so does an accepted falling transition.
- R5: A cycle with `rd_chg` high clears all change flags at the next clock edge, except any flag whose input is accepted on that same edge.
- R6: A transition accepted in the same cycle as a change-register read leaves that input's flag set after the read.
- R7: `irq` is high exactly when `irq_en` is high and at least one change flag is set.
- R8: Pin changes on inputs 6..4 never set any change flag.
- R9: After synchronous reset, all flags are 0, all filtered levels are 1, and `irq` is low.
- R10: Ticks that arrive while the inputs are steady leave the flags and the filtered levels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_tick | input | 1 | One-cycle sampling enable |
| pin_in | input | 7 | Raw input pins |
| rd_chg | input | 1 | Read strobe for the change register (clears flags) |
| rd_port | input | 1 | Read strobe for the raw port |
| irq_en | input | 1 | Interrupt enable |
| rd_data | output | 8 | Read data selected by the strobes |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `smp_tick` is a single-cycle pulse, so that a flag can only appear in the cycle after a tick. They also assume the pins stay steady for at least three clocks before a tick that is meant to see a new level, which lets the synchronizer settle. The bench drives every input on the falling clock edge, raises the tick for exactly one cycle, and waits several clocks after each pin change. The read strobe is held for one cycle per read.

// File: rtl/icd_pkg.sv
// Shared widths and types for the input change-of-state detector.
package icd_pkg;
    localparam int RD_W = 8;
    typedef logic [RD_W-1:0] rd_word_t;
endpackage

// File: rtl/icd_sync.sv
// Two-flop synchronizer for a bus of asynchronous inputs.
// Assumes each bit is independent; the reset value is the idle pin level.
module icd_sync #(
    parameter int   W       = 4,
    parameter logic RST_LVL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture of the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= {W{RST_LVL}};
            q    <= {W{RST_LVL}};
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/icd_qual.sv
// Two-sample qualifier for one input: it accepts a new level only when two
// successive ticks see it. Assumes tick is a one-cycle pulse and din is
// already synchronized.
module icd_qual #(
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic level,
    output logic accept
);
    logic prev_smp;

    // The accept strobe fires on the tick that confirms the new level.
    assign accept = tick && (din == prev_smp) && (din != level);

    // Sample history and the accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_smp <= RST_LVL;
            level    <= RST_LVL;
        end else if (tick) begin
            prev_smp <= din;
            if (accept) level <= din;
        end
    end
endmodule

// File: rtl/icd_top.sv
// Input change-of-state detector: it synchronizes and qualifies the low
// inputs, latches sticky change flags, and multiplexes port and change
// register reads. Assumes smp_tick is a single-cycle pulse.
module icd_top
    import icd_pkg::*;
#(
    parameter int   PORT_W  = 7,
    parameter int   CHG_W   = 4,
    parameter logic RST_LVL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_tick,
    input  logic [PORT_W-1:0] pin_in,
    input  logic              rd_chg,
    input  logic              rd_port,
    input  logic              irq_en,
    output logic [RD_W-1:0]   rd_data,
    output logic              irq
);
    localparam int PAD_W = RD_W - PORT_W;
    localparam int LVL_W = RD_W - CHG_W;

    logic [CHG_W-1:0] sync_in;
    logic [CHG_W-1:0] filt_lvl;
    logic [CHG_W-1:0] acc;
    logic [CHG_W-1:0] chg_flg;
    rd_word_t         chg_word;

    icd_sync #(.W(CHG_W), .RST_LVL(RST_LVL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in[CHG_W-1:0]),
        .q     (sync_in)
    );

    for (genvar i = 0; i < CHG_W; i++) begin : g_ch
        icd_qual #(.RST_LVL(RST_LVL)) u_qual (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (smp_tick),
            .din    (sync_in[i]),
            .level  (filt_lvl[i]),
            .accept (acc[i])
        );
    end

    // Sticky flags: a read clears them, a same-cycle acceptance wins.
    always_ff @(posedge clk) begin
        if (!rst_n) chg_flg <= '0;
        else        chg_flg <= (rd_chg ? '0 : chg_flg) | acc;
    end

    // Assemble the change-register word: levels above, flags below.
    always_comb begin
        chg_word = '0;
        chg_word[CHG_W-1:0] = chg_flg;
        chg_word[CHG_W +: LVL_W] = LVL_W'(filt_lvl);
    end

    // Read multiplexer; the change register takes priority.
    always_comb begin
        if (rd_chg)       rd_data = chg_word;
        else if (rd_port) rd_data = {{PAD_W{1'b1}}, pin_in};
        else              rd_data = '0;
    end

    // Maskable interrupt from any pending flag.
    assign irq = irq_en && (|chg_flg);
endmodule

// File: rtl/icd_checker.sv
// Property checker for icd_top, bound to every instance.
module icd_checker #(
    parameter int CHG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_tick,
    input logic             rd_chg,
    input logic             rd_port,
    input logic             irq_en,
    input logic             irq,
    input logic [7:0]       rd_data,
    input logic [CHG_W-1:0] chg_flg,
    input logic [CHG_W-1:0] filt_lvl
);
    assert_flag_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((chg_flg & ~$past(chg_flg)) != '0) |-> $past(smp_tick));

    assert_level_change_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_lvl != $past(filt_lvl)) |->
        ((chg_flg & (filt_lvl ^ $past(filt_lvl))) == (filt_lvl ^ $past(filt_lvl))));

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_chg && !smp_tick) |=> (chg_flg == '0));

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    assert_port_top_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_port && !rd_chg) |-> rd_data[7]);
endmodule

bind icd_top icd_checker #(.CHG_W(CHG_W)) u_icd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_tick (smp_tick),
    .rd_chg   (rd_chg),
    .rd_port  (rd_port),
    .irq_en   (irq_en),
    .irq      (irq),
    .rd_data  (rd_data),
    .chg_flg  (chg_flg),
    .filt_lvl (filt_lvl)
);

// File: tb/tb_icd_top.sv
`timescale 1ns/1ps
module tb_icd_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_tick = 1'b0;
    logic [6:0] pin_in = 7'h7F;
    logic       rd_chg = 1'b0;
    logic       rd_port = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq;
    int total = 0;
    int bad = 0;
    logic [7:0] got;

    always #2.5 clk = ~clk;

    icd_top dut (.clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .pin_in(pin_in),
                 .rd_chg(rd_chg), .rd_port(rd_port), .irq_en(irq_en),
                 .rd_data(rd_data), .irq(irq));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick1();
        @(negedge clk) smp_tick = 1'b1;
        @(negedge clk) smp_tick = 1'b0;
    endtask

    task automatic set_pins(input logic [6:0] v);
        @(negedge clk) pin_in = v;
        idle(4);
    endtask

    // Sample the change register; the flags clear at the next edge.
    task automatic read_chg(output logic [7:0] v);
        @(negedge clk) rd_chg = 1'b1;
        #1 v = rd_data;
        @(negedge clk) rd_chg = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9 idle bus", rd_data, 8'h00);
        chk("R9 irq", {7'b0, irq}, 8'h00);
        read_chg(got);
        chk("R9 reset word", got, 8'hF0);
    endtask

    task automatic t_port();
        @(negedge clk) pin_in = 7'h2A; rd_port = 1'b1;
        #1 chk("R1 port read", rd_data, 8'hAA);
        @(negedge clk) rd_port = 1'b0; pin_in = 7'h7F;
        idle(4);
        @(negedge clk) rd_port = 1'b1; rd_chg = 1'b1;
        #1 chk("R2 priority", rd_data, 8'hF0);
        @(negedge clk) rd_port = 1'b0; rd_chg = 1'b0;
    endtask

    task automatic t_glitch();
        set_pins(7'h7E);
        tick1();
        set_pins(7'h7F);
        tick1(); tick1();
        read_chg(got);
        chk("R3 glitch ignored", got, 8'hF0);
    endtask

    task automatic t_fall_rise();
        set_pins(7'h7E);
        tick1();
        read_chg(got);
        chk("R3 one tick not enough", got, 8'hF0);
        tick1();
        read_chg(got);
        chk("R4 falling sets flag", got, 8'hE1);
        read_chg(got);
        chk("R5 cleared by read", got, 8'hE0);
        tick1(); tick1();
        read_chg(got);
        chk("R10 steady ticks", got, 8'hE0);
        set_pins(7'h7F);
        tick1(); tick1();
        read_chg(got);
        chk("R4 rising sets flag", got, 8'hF1);
    endtask

    task automatic t_upper();
        set_pins(7'h0F);
        tick1(); tick1();
        read_chg(got);
        chk("R8 upper pins ignored", got, 8'hF0);
        set_pins(7'h7F);
    endtask

    task automatic t_irq();
        set_pins(7'h7B);
        tick1(); tick1();
        @(negedge clk);
        chk("R7 masked", {7'b0, irq}, 8'h00);
        irq_en = 1'b1;
        #1 chk("R7 enabled", {7'b0, irq}, 8'h01);
        read_chg(got);
        chk("R2 flag bit2", got, 8'hB4);
        #1 chk("R7 drops after read", {7'b0, irq}, 8'h00);
        irq_en = 1'b0;
        set_pins(7'h7F);
        tick1(); tick1();
        read_chg(got);
    endtask

    task automatic t_collide();
        // Flag on input 1 first, then a read coinciding with input 3 accepting.
        set_pins(7'h7D);
        tick1(); tick1();
        set_pins(7'h75);
        tick1();
        @(negedge clk) smp_tick = 1'b1; rd_chg = 1'b1;
        #1 chk("R2 before collide", rd_data, 8'hD2);
        @(negedge clk) smp_tick = 1'b0; rd_chg = 1'b0;
        read_chg(got);
        chk("R6 kept on collision", got, 8'h58);
    endtask

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_port();
        t_glitch();
        t_fall_rise();
        t_upper();
        t_irq();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule